// File: doc/BRIEF.md
# Interrupt and Bus Request Arbiter

This block sits on the processor side of a bus. It decides what the core does when an instruction or a machine cycle ends. The decoder reports those points as single-cycle strobes. The arbiter weighs three requests: an active-low maskable interrupt line, a non-maskable line that triggers on a falling edge, and an active-low request from an external bus master. Each request type has its own priority, its own sampling point and its own masking rule.

The arbiter holds the interrupt-enable flag, the two-bit interrupt mode and an 8-bit vector page register. When it accepts an interrupt it reports where execution resumes. In mode 1 that is a fixed restart address. In mode 2 it is an address built from the page register and a byte supplied by the device. In mode 0 it raises a flag saying the next opcode is the byte taken from the data bus. The non-maskable interrupt always resumes at a fixed address of its own.

For an external bus master, the arbiter first drops the bus-drive enable, so the address bus, data bus and strobes float. Only then does it acknowledge the request. When the master lets go, it reverses that order.

Top module: `irq_bus_arbiter`

## Requirements
- R1: While rst_n is low, and for RST_HOLD (default 3) clocks after it rises, bus_oe is 0, busack_n, ack_m1_n and ack_iorq_n are 1, and vec_valid is 0. Reset clears the enable flag (ie_state 0) and the page register, and selects mode 0.
- R2: A falling edge on nmi_n is latched until it is serviced at an instruction end, whatever the enable flag holds. vec_valid then rises in the cycle after the strobe, with vec_nmi=1 and vec_addr=NMI_ADDR (default 0x0066), and no acknowledge cycle is run. A level held low does not trigger again.
- R3: When a latched non-maskable request and an active maskable request meet at the same instruction end, the non-maskable one is taken.
- R4: int_n is honoured only when the enable flag is set and instr_end is high in that same cycle. A low level at any other time has no effect.
- R5: In the cycle after a maskable acceptance, ack_m1_n and ack_iorq_n are both 0 for exactly one cycle. data_in is captured in that cycle, and vec_valid is 1 in the cycle that follows.
- R6: In mode 1 (mode_val=1), vec_addr=FIXED_ADDR (default 0x0038) and vec_from_bus=0.
- R7: In mode 2 (mode_val=2), vec_addr is the page register in the upper byte and the captured device byte in the lower byte, with vec_from_bus=0.
- R8: In mode 0 (mode_val=0), vec_from_bus=1 and vec_opcode equals the captured device byte.
- R9: ie_set sets the enable flag and ie_clr clears it. ie_clr wins if both arrive together. Accepting any interrupt clears the flag at the acceptance edge.
- R10: busreq_n is honoured only when mcyc_end is high. In the next cycle bus_oe goes to 0 while busack_n stays 1, and one cycle later busack_n goes to 0. After busreq_n returns high, busack_n rises in the next cycle and bus_oe rises one cycle after that.
- R11: A bus request at a boundary that also ends an instruction beats a latched non-maskable request. The latched request stays pending and is taken at the first instruction end after the bus is returned. Instruction-end strobes are ignored while the bus is away.
- R12: A mode write with mode_val=3 is ignored, and the previous mode is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_n | input | 1 | Maskable interrupt request, active low |
| nmi_n | input | 1 | Non-maskable request, falling-edge triggered |
| busreq_n | input | 1 | External bus request, active low |
| instr_end | input | 1 | Strobe: last cycle of an instruction |
| mcyc_end | input | 1 | Strobe: last cycle of a machine cycle |
| ie_set | input | 1 | Set the enable flag |
| ie_clr | input | 1 | Clear the enable flag |
| mode_wr | input | 1 | Load the interrupt mode from mode_val |
| mode_val | input | 2 | New interrupt mode (0, 1, 2; 3 ignored) |
| vec_wr | input | 1 | Load the page register from vec_val |
| vec_val | input | DATA_W | New page register value |
| data_in | input | DATA_W | Byte the device places on the data bus |
| ie_state | output | 1 | Current enable flag |
| ack_m1_n | output | 1 | Opcode-fetch indicator, low during the acknowledge cycle |
| ack_iorq_n | output | 1 | IO-request indicator, low during the acknowledge cycle |
| vec_valid | output | 1 | One-cycle pulse: resume information valid |
| vec_nmi | output | 1 | Accepted interrupt was non-maskable |
| vec_addr | output | ADDR_W | Resume address |
| vec_from_bus | output | 1 | Next opcode comes from vec_opcode (mode 0) |
| vec_opcode | output | DATA_W | Byte captured in the acknowledge cycle |
| bus_oe | output | 1 | Drive enable for address, data and strobes |
| busack_n | output | 1 | Bus acknowledge, active low |

## Verification
The hardest case to reach is R11. A falling edge on the non-maskable line must already be latched when a combined instruction-and-cycle boundary meets a bus request. Then, while the bus is held, further instruction-end strobes must be shown to do nothing. The bench builds this case directly. It pulses nmi_n early, lowers busreq_n, fires both strobes together, strobes instr_end again during the hold, and only then returns the bus and expects the delayed service.

Randomized boundaries interleave enable, mode and page writes (including the reserved mode value) with edge pulses and maskable levels. This drives all three modes and both precedence orders against a bench model of the enable flag and the pending flag.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   typedef enum logic [1:0] {
      BG_RUN  = 2'd0,
      BG_REL  = 2'd1,
      BG_HELD = 2'd2,
      BG_RET  = 2'd3
   } bg_state_t;

   typedef enum logic [1:0] {
      VS_IDLE = 2'd0,
      VS_ACK  = 2'd1,
      VS_DONE = 2'd2
   } vs_state_t;

   localparam logic [1:0] MODE_FETCH = 2'd0;
   localparam logic [1:0] MODE_FIXED = 2'd1;
   localparam logic [1:0] MODE_TABLE = 2'd2;
   localparam logic [1:0] MODE_RSVD  = 2'd3;

endpackage

// File: rtl/irq_rst_stretch.sv
module irq_rst_stretch #(
   parameter int HOLD = 3
) (
   input  logic clk,
   input  logic rst_n,
   output logic core_rst_n
);
   localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
   localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         core_rst_n <= 1'b0;
      end else begin
         if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
         core_rst_n <= core_rst_n | (cnt_q == LAST);
      end
   end

   AST_RST_STAYS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(core_rst_n) |-> core_rst_n);   // R1
endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_n,
   input  logic take,
   output logic nmi_req
);
   logic nmi_s;
   logic prev_q;
   logic pend_q;
   logic fall;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign nmi_s = nmi_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= {sh_q[SYNC_STAGES-2:0], nmi_n};
         end
         assign nmi_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   assign fall    = prev_q & ~nmi_s;
   assign nmi_req = pend_q | fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         pend_q <= 1'b0;
      end else begin
         prev_q <= nmi_s;
         pend_q <= (pend_q | fall) & ~take;
      end
   end

   AST_NMI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && !take |=> pend_q);   // R2
endmodule

// File: rtl/irq_bus_grant.sv
module irq_bus_grant
   import irq_arb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic busreq_n,
   input  logic mcyc_end,
   input  logic int_idle,
   output logic grant_now,
   output logic run,
   output logic bus_oe,
   output logic busack_n
);
   bg_state_t st_q, st_d;

   assign run       = (st_q == BG_RUN);
   assign grant_now = run & mcyc_end & ~busreq_n & int_idle;
   assign bus_oe    = rst_n & run;
   assign busack_n  = (st_q != BG_HELD);

   always_comb begin
      st_d = st_q;
      case (st_q)
         BG_RUN:  if (grant_now) st_d = BG_REL;
         BG_REL:  st_d = BG_HELD;
         BG_HELD: if (busreq_n) st_d = BG_RET;
         default: st_d = BG_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= BG_RUN;
      else        st_q <= st_d;
   end

   AST_ACK_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busack_n) |-> $past(!bus_oe));   // R10
   AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_oe) |-> $past(mcyc_end && !busreq_n));   // R10
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
   import irq_arb_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] NMI_ADDR   = ADDR_W'('h0066),
   parameter logic [ADDR_W-1:0] FIXED_ADDR = ADDR_W'('h0038)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary,
   input  logic              int_n,
   input  logic              nmi_req,
   input  logic              ie_set,
   input  logic              ie_clr,
   input  logic              mode_wr,
   input  logic [1:0]        mode_val,
   input  logic              vec_wr,
   input  logic [DATA_W-1:0] vec_val,
   input  logic [DATA_W-1:0] data_in,
   output logic              nmi_take,
   output logic              idle,
   output logic              ie_state,
   output logic              ack_n,
   output logic              vec_valid,
   output logic              vec_nmi,
   output logic [ADDR_W-1:0] vec_addr,
   output logic              vec_from_bus,
   output logic [DATA_W-1:0] vec_opcode
);
   vs_state_t         st_q;
   logic              ie_q;
   logic [1:0]        mode_q;
   logic [1:0]        held_mode_q;
   logic [DATA_W-1:0] page_q;
   logic              int_take;

   assign idle     = (st_q == VS_IDLE);
   assign nmi_take = idle & boundary & nmi_req;
   assign int_take = idle & boundary & ~nmi_req & ie_q & ~int_n;
   assign ie_state = ie_q;
   assign ack_n    = (st_q != VS_ACK);
   assign vec_valid = (st_q == VS_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q   <= 1'b0;
         mode_q <= MODE_FETCH;
         page_q <= '0;
      end else begin
         if (nmi_take | int_take) ie_q <= 1'b0;
         else if (ie_clr)         ie_q <= 1'b0;
         else if (ie_set)         ie_q <= 1'b1;
         if (mode_wr && mode_val != MODE_RSVD) mode_q <= mode_val;
         if (vec_wr) page_q <= vec_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= VS_IDLE;
         held_mode_q  <= MODE_FETCH;
         vec_nmi      <= 1'b0;
         vec_addr     <= '0;
         vec_from_bus <= 1'b0;
         vec_opcode   <= '0;
      end else begin
         case (st_q)
            VS_IDLE: begin
               if (nmi_take) begin
                  st_q         <= VS_DONE;
                  vec_nmi      <= 1'b1;
                  vec_addr     <= NMI_ADDR;
                  vec_from_bus <= 1'b0;
                  vec_opcode   <= '0;
               end else if (int_take) begin
                  st_q        <= VS_ACK;
                  held_mode_q <= mode_q;
               end
            end
            VS_ACK: begin
               st_q       <= VS_DONE;
               vec_nmi    <= 1'b0;
               vec_opcode <= data_in;
               case (held_mode_q)
                  MODE_FIXED: begin
                     vec_addr     <= FIXED_ADDR;
                     vec_from_bus <= 1'b0;
                  end
                  MODE_TABLE: begin
                     vec_addr     <= {page_q, data_in};
                     vec_from_bus <= 1'b0;
                  end
                  default: begin
                     vec_addr     <= '0;
                     vec_from_bus <= 1'b1;
                  end
               endcase
            end
            default: st_q <= VS_IDLE;
         endcase
      end
   end

   AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q != MODE_RSVD);   // R12
   AST_ACCEPT_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_take || int_take) |=> !ie_q);   // R9
   AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == VS_ACK) |=> (st_q == VS_DONE));   // R5
   AST_NMI_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid && vec_nmi) |-> (vec_addr == NMI_ADDR && !vec_from_bus));   // R2
endmodule

// File: rtl/irq_bus_arbiter.sv
module irq_bus_arbiter
   import irq_arb_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int RST_HOLD    = 3,
   parameter int NMI_SYNC    = 0,
   parameter logic [ADDR_W-1:0] NMI_ADDR   = ADDR_W'('h0066),
   parameter logic [ADDR_W-1:0] FIXED_ADDR = ADDR_W'('h0038)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              int_n,
   input  logic              nmi_n,
   input  logic              busreq_n,
   input  logic              instr_end,
   input  logic              mcyc_end,
   input  logic              ie_set,
   input  logic              ie_clr,
   input  logic              mode_wr,
   input  logic [1:0]        mode_val,
   input  logic              vec_wr,
   input  logic [DATA_W-1:0] vec_val,
   input  logic [DATA_W-1:0] data_in,
   output logic              ie_state,
   output logic              ack_m1_n,
   output logic              ack_iorq_n,
   output logic              vec_valid,
   output logic              vec_nmi,
   output logic [ADDR_W-1:0] vec_addr,
   output logic              vec_from_bus,
   output logic [DATA_W-1:0] vec_opcode,
   output logic              bus_oe,
   output logic              busack_n
);
   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("irq_bus_arbiter: ADDR_W must be twice DATA_W for paged vectors");
      end
      if (RST_HOLD < 1) begin : g_bad_hold
         $error("irq_bus_arbiter: RST_HOLD must be at least 1");
      end
      if (NMI_SYNC == 1 || NMI_SYNC < 0) begin : g_bad_sync
         $error("irq_bus_arbiter: NMI_SYNC must be 0 or at least 2");
      end
   endgenerate

   logic core_rst_n;
   logic nmi_req;
   logic nmi_take;
   logic int_idle;
   logic grant_now;
   logic bus_run;
   logic ack_n;
   logic boundary;

   assign boundary   = instr_end & bus_run & ~grant_now;
   assign ack_m1_n   = ack_n;
   assign ack_iorq_n = ack_n;

   irq_rst_stretch #(.HOLD(RST_HOLD)) u_rst (
      .clk        (clk),
      .rst_n      (rst_n),
      .core_rst_n (core_rst_n)
   );

   irq_nmi_latch #(.SYNC_STAGES(NMI_SYNC)) u_nmi (
      .clk     (clk),
      .rst_n   (core_rst_n),
      .nmi_n   (nmi_n),
      .take    (nmi_take),
      .nmi_req (nmi_req)
   );

   irq_bus_grant u_bus (
      .clk       (clk),
      .rst_n     (core_rst_n),
      .busreq_n  (busreq_n),
      .mcyc_end  (mcyc_end),
      .int_idle  (int_idle),
      .grant_now (grant_now),
      .run       (bus_run),
      .bus_oe    (bus_oe),
      .busack_n  (busack_n)
   );

   irq_vector_unit #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .NMI_ADDR   (NMI_ADDR),
      .FIXED_ADDR (FIXED_ADDR)
   ) u_vec (
      .clk          (clk),
      .rst_n        (core_rst_n),
      .boundary     (boundary),
      .int_n        (int_n),
      .nmi_req      (nmi_req),
      .ie_set       (ie_set),
      .ie_clr       (ie_clr),
      .mode_wr      (mode_wr),
      .mode_val     (mode_val),
      .vec_wr       (vec_wr),
      .vec_val      (vec_val),
      .data_in      (data_in),
      .nmi_take     (nmi_take),
      .idle         (int_idle),
      .ie_state     (ie_state),
      .ack_n        (ack_n),
      .vec_valid    (vec_valid),
      .vec_nmi      (vec_nmi),
      .vec_addr     (vec_addr),
      .vec_from_bus (vec_from_bus),
      .vec_opcode   (vec_opcode)
   );

   AST_ACK_WITH_BUS: assert property (@(posedge clk) disable iff (!core_rst_n)
      !ack_m1_n |-> (bus_oe && busack_n));   // R5
   AST_NO_RESULT_WHILE_AWAY: assert property (@(posedge clk) disable iff (!core_rst_n)
      !busack_n |-> !vec_valid);   // R11
endmodule

// File: tb/irq_bus_arbiter_bench.sv
module irq_bus_arbiter_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic int_n = 1'b1, nmi_n = 1'b1, busreq_n = 1'b1;
   logic instr_end = 1'b0, mcyc_end = 1'b0;
   logic ie_set = 1'b0, ie_clr = 1'b0, mode_wr = 1'b0, vec_wr = 1'b0;
   logic [1:0] mode_val = 2'd0;
   logic [7:0] vec_val = 8'h00, data_in = 8'h00;
   logic ie_state, ack_m1_n, ack_iorq_n, vec_valid, vec_nmi, vec_from_bus, bus_oe, busack_n;
   logic [15:0] vec_addr;
   logic [7:0] vec_opcode;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   bit m_ie = 1'b0;
   bit m_pend = 1'b0;
   logic [1:0] m_mode = 2'd0;
   logic [7:0] m_page = 8'h00;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_bus_arbiter u_irq_bus_arbiter (
      .clk(clk), .rst_n(rst_n), .int_n(int_n), .nmi_n(nmi_n), .busreq_n(busreq_n),
      .instr_end(instr_end), .mcyc_end(mcyc_end), .ie_set(ie_set), .ie_clr(ie_clr),
      .mode_wr(mode_wr), .mode_val(mode_val), .vec_wr(vec_wr), .vec_val(vec_val),
      .data_in(data_in), .ie_state(ie_state), .ack_m1_n(ack_m1_n), .ack_iorq_n(ack_iorq_n),
      .vec_valid(vec_valid), .vec_nmi(vec_nmi), .vec_addr(vec_addr),
      .vec_from_bus(vec_from_bus), .vec_opcode(vec_opcode), .bus_oe(bus_oe), .busack_n(busack_n)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic do_ie(input bit s, input bit c);
      @(negedge clk); ie_set = s; ie_clr = c;
      @(negedge clk); ie_set = 1'b0; ie_clr = 1'b0;
      if (c) m_ie = 1'b0; else if (s) m_ie = 1'b1;
   endtask

   task automatic do_mode(input logic [1:0] m);
      @(negedge clk); mode_wr = 1'b1; mode_val = m;
      @(negedge clk); mode_wr = 1'b0;
      if (m != 2'd3) m_mode = m;
   endtask

   task automatic do_page(input logic [7:0] v);
      @(negedge clk); vec_wr = 1'b1; vec_val = v;
      @(negedge clk); vec_wr = 1'b0;
      m_page = v;
   endtask

   task automatic nmi_pulse();
      @(negedge clk); nmi_n = 1'b0;
      @(negedge clk); nmi_n = 1'b1;
      m_pend = 1'b1;
   endtask

   // Predict and check one instruction-end boundary (both strobes together).
   task automatic boundary(input string req);
      int kind;
      kind = m_pend ? 2 : ((m_ie && int_n == 1'b0) ? 1 : 0);
      @(negedge clk); instr_end = 1'b1; mcyc_end = 1'b1;
      tick();
      if (kind == 2) begin
         chk(req, "nmi vec_valid", vec_valid, 1);
         chk(req, "nmi vec_nmi", vec_nmi, 1);
         chk(req, "nmi addr", vec_addr, 16'h0066);
         chk(req, "nmi no ack", ack_m1_n, 1);
         m_pend = 1'b0;
         m_ie = 1'b0;
      end else if (kind == 1) begin
         chk("R5", "ack m1", ack_m1_n, 0);
         chk("R5", "ack iorq", ack_iorq_n, 0);
         chk("R5", "no early valid", vec_valid, 0);
      end else begin
         chk(req, "no accept valid", vec_valid, 0);
         chk(req, "no accept ack", ack_m1_n, 1);
      end
      @(negedge clk); instr_end = 1'b0; mcyc_end = 1'b0;
      if (kind == 1) begin
         tick();
         chk("R5", "valid after ack", vec_valid, 1);
         chk("R5", "ack over", ack_m1_n, 1);
         chk(req, "not nmi", vec_nmi, 0);
         if (m_mode == 2'd1) begin
            chk("R6", "fixed addr", vec_addr, 16'h0038);
            chk("R6", "fixed not bus", vec_from_bus, 0);
         end else if (m_mode == 2'd2) begin
            chk("R7", "paged addr", vec_addr, {m_page, data_in});
            chk("R7", "paged not bus", vec_from_bus, 0);
         end else begin
            chk("R8", "from bus", vec_from_bus, 1);
            chk("R8", "opcode", vec_opcode, data_in);
         end
         m_ie = 1'b0;
      end
      tick();
      chk("R9", "ie after boundary", ie_state, m_ie);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R1: reset and its stretch
      repeat (4) @(posedge clk);
      #1;
      chk("R1", "oe in reset", bus_oe, 0);
      chk("R1", "busack in reset", busack_n, 1);
      @(negedge clk); rst_n = 1'b1;
      tick(); tick();
      chk("R1", "oe during hold", bus_oe, 0);
      chk("R1", "ack during hold", ack_m1_n, 1);
      chk("R1", "valid during hold", vec_valid, 0);
      tick();
      chk("R1", "oe after hold", bus_oe, 1);
      chk("R1", "ie after reset", ie_state, 0);
      chk("R1", "busack after reset", busack_n, 1);

      // R1/R8: default mode 0
      do_ie(1, 0);
      int_n = 1'b0; data_in = 8'hC7;
      boundary("R8");
      // R1: page register cleared by reset
      do_mode(2'd2);
      do_ie(1, 0);
      data_in = 8'h5A;
      @(negedge clk); instr_end = 1'b1; mcyc_end = 1'b1;
      tick(); @(negedge clk); instr_end = 1'b0; mcyc_end = 1'b0;
      tick();
      chk("R1", "page zero after reset", vec_addr, 16'h005A);
      m_ie = 1'b0;
      repeat (2) @(negedge clk);

      // R4: enable clear blocks maskable
      boundary("R4");
      // R4: level off boundary has no effect
      do_ie(1, 0);
      int_n = 1'b0;
      repeat (5) @(negedge clk);
      chk("R4", "no ack off boundary", ack_m1_n, 1);
      int_n = 1'b1;
      boundary("R4");
      chk("R4", "ie kept", ie_state, 1);

      // R9: clear beats set
      do_ie(1, 1);
      tick();
      chk("R9", "clear wins", ie_state, 0);

      // R12 and R6
      do_mode(2'd1);
      do_mode(2'd3);
      do_ie(1, 0);
      int_n = 1'b0; data_in = 8'h11;
      boundary("R12");

      // R2: edge while disabled; held low level does not repeat
      @(negedge clk); nmi_n = 1'b0; m_pend = 1'b1;
      repeat (3) @(negedge clk);
      boundary("R2");
      boundary("R2");
      @(negedge clk); nmi_n = 1'b1;

      // R3: both pending
      do_ie(1, 0);
      int_n = 1'b0;
      nmi_pulse();
      boundary("R3");
      chk("R3", "ie cleared by nmi", ie_state, 0);
      int_n = 1'b1;

      // R10: request without boundary is not honoured
      @(negedge clk); busreq_n = 1'b0;
      tick(); tick();
      chk("R10", "no grant off boundary", bus_oe, 1);
      @(negedge clk); mcyc_end = 1'b1;
      tick();
      chk("R10", "released", bus_oe, 0);
      chk("R10", "not yet acked", busack_n, 1);
      @(negedge clk); mcyc_end = 1'b0;
      tick();
      chk("R10", "acked", busack_n, 0);
      tick(); tick();
      chk("R10", "still held", busack_n, 0);
      @(negedge clk); busreq_n = 1'b1;
      tick();
      chk("R10", "ack dropped", busack_n, 1);
      chk("R10", "still floating", bus_oe, 0);
      tick();
      chk("R10", "driving again", bus_oe, 1);

      // R11: bus beats pending nmi
      nmi_pulse();
      @(negedge clk); busreq_n = 1'b0; instr_end = 1'b1; mcyc_end = 1'b1;
      tick();
      chk("R11", "bus granted", bus_oe, 0);
      chk("R11", "nmi deferred", vec_valid, 0);
      @(negedge clk); instr_end = 1'b0; mcyc_end = 1'b0;
      tick();
      @(negedge clk); instr_end = 1'b1; mcyc_end = 1'b1;
      tick();
      chk("R11", "strobe ignored while away", vec_valid, 0);
      @(negedge clk); instr_end = 1'b0; mcyc_end = 1'b0; busreq_n = 1'b1;
      tick(); tick();
      chk("R11", "bus back", bus_oe, 1);
      @(negedge clk);
      boundary("R11");

      // Random mix
      for (int i = 0; i < 300; i++) begin
         int r;
         r = $urandom % 16;
         if (r < 4) do_ie(r[0], r[1] & r[0]);
         if ($urandom % 5 == 0) do_mode(2'($urandom % 4));
         if ($urandom % 6 == 0) do_page(8'($urandom));
         if ($urandom % 4 == 0) nmi_pulse();
         @(negedge clk);
         int_n = 1'($urandom % 2);
         data_in = 8'($urandom);
         boundary(m_pend ? "R2" : "R4");
      end

      finish_run();
   end

   initial begin
      void'($urandom(32'd12345));
   end
endmodule